// File: doc/BRIEF.md
# Memory-card boot record image loader

This block fetches a boot image from a memory card without any filesystem support. It sits behind an abstract sector-read port: it asks for a sector number, and the card side returns that sector as a stream of 512 bytes. The block first reads absolute sector 0. Inside that sector it looks for a 16-byte boot record at a fixed byte offset, and it checks the usual boot-sector marker at the end of the sector. If both are present, the record gives the first sector of the image. The block then reads consecutive raw sectors from that point and turns the bytes into 32-bit words. These words go out on a write port toward RAM.

A load begins with a `start` pulse. It ends with a one-cycle `done` pulse, or with `fail` held high together with a reason code. Every streaming edge uses valid/ready, and a transfer happens on a clock edge where both are high. The sector request (`req_valid`/`req_ready`) keeps its valid and sector number steady until it is accepted. The byte stream (`rd_valid`/`rd_ready`) may be stalled from either side: the loader drops `rd_ready` while a packed word still waits for the RAM. The word write (`wr_valid`/`wr_ready`) keeps its address and data steady until it is accepted. `rd_err` is a plain status input from the card side.

Top module: `sd_boot_loader`

## Requirements
- R1: After `start`, the first sector request is for sector 0. While the loader is not loading, it raises neither a request nor a write.
- R2: The record at byte offset `REC_OFS` (default 480) of sector 0 must hold the 11-character tag `SIG_TEXT` (default ASCII "BOOTIMAGE01") in bytes 0 to 10, and 0x00 in byte 11. If any of these bytes differs and the marker is correct, the load fails with `fail_code` 2. No word is written and no further sector is requested.
- R3: Byte 510 of sector 0 must be 0x55 and byte 511 must be 0xAA. If either differs, the load fails with `fail_code` 1, even when the record tag is also wrong. No word is written.
- R4: Record bytes 12 to 15 hold the image start sector, least significant byte first. The image is read from consecutive sectors, beginning at that sector, with exactly ceil(`IMG_WORDS`/128) requests.
- R5: Image byte k goes to bits 8*(k mod 4)+7 down to 8*(k mod 4) of word k/4. Word addresses start at 0 and step by 1.
- R6: Exactly `IMG_WORDS` words are written. The remaining bytes of the final sector are still taken from the stream and are then discarded.
- R7: If `rd_err` is high while a sector is being streamed, the load aborts with `fail_code` 3.
- R8: If the port makes no progress for `TMO_CYC` cycles in a row while the loader waits on it, the load aborts with `fail_code` 3. No progress means a request that is not accepted, or `rd_ready` high with no byte offered.
- R9: `done` is high for exactly one cycle after the last word has been accepted. `fail` and `fail_code` stay steady until the next `start`.
- R10: While a transfer waits for its ready signal, `req_valid`, `req_sector`, `wr_valid`, `wr_addr` and `wr_data` stay steady. An abort is the only exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a load; accepted when idle or failed |
| req_valid | output | 1 | Sector request valid |
| req_ready | input | 1 | Sector request accepted |
| req_sector | output | 32 | Absolute sector number requested |
| rd_valid | input | 1 | Sector byte valid |
| rd_ready | output | 1 | Loader takes a sector byte |
| rd_data | input | 8 | Sector byte, in order from byte 0 to byte 511 |
| rd_err | input | 1 | Card-side read error |
| wr_valid | output | 1 | Image word valid |
| wr_ready | input | 1 | RAM takes the word |
| wr_addr | output | AW | Word address, AW = clog2(IMG_WORDS) |
| wr_data | output | 32 | Image word, little-endian packed |
| done | output | 1 | One-cycle pulse: load complete |
| fail | output | 1 | Load failed; held until next start |
| fail_code | output | 2 | 1 marker, 2 record tag, 3 read error or timeout |

## Verification
Suppose the in-sector byte counter slips. Then the record check or the start-sector capture reads the wrong bytes, and this shows up at the end of sector 0 as a wrong fail code, or as a wrong second `req_sector`. Suppose the word packer's lane state is wrong. Then the very first `wr_data` disagrees with the scoreboard, a few cycles after the image bytes start. Suppose the sector or discard counters are wrong. Then the request count, the write count, or the card stream left half-read when `done` rises shows it, within one sector of the end of the load.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_REQ0, S_RD0, S_EVAL, S_REQN, S_RDN, S_DRAIN, S_DONE, S_FAIL
  } ld_state_t;

  localparam logic [1:0] FC_NONE = 2'd0;
  localparam logic [1:0] FC_MARK = 2'd1;
  localparam logic [1:0] FC_TAG  = 2'd2;
  localparam logic [1:0] FC_IO   = 2'd3;

  localparam int SECT_BYTES = 512;
endpackage

// File: rtl/sdl_rec_check.sv
module sdl_rec_check #(
  parameter int          REC_OFS  = 480,
  parameter logic [87:0] SIG_TEXT = "BOOTIMAGE01"
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        byte_v,
  input  logic [8:0]  idx,
  input  logic [7:0]  byte_d,
  output logic        tag_ok,
  output logic        mark_ok,
  output logic [31:0] start_sec
);
  localparam logic [8:0] OFS9 = 9'(REC_OFS);

  logic [8:0] pos;
  logic       in_rec;
  assign pos    = idx - OFS9;
  assign in_rec = (idx >= OFS9) && (pos < 9'd16);

  function automatic logic [7:0] want_char(input logic [8:0] p);
    if (p < 9'd11) return SIG_TEXT[8*(10-int'(p)) +: 8];
    return 8'h00;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_ok    <= 1'b1;
      mark_ok   <= 1'b1;
      start_sec <= '0;
    end else if (clr) begin
      tag_ok    <= 1'b1;
      mark_ok   <= 1'b1;
      start_sec <= '0;
    end else if (byte_v) begin
      if (in_rec && pos < 9'd12 && byte_d != want_char(pos)) tag_ok <= 1'b0;
      if (in_rec && pos >= 9'd12) start_sec[8*pos[1:0] +: 8] <= byte_d;
      if (idx == 9'd510 && byte_d != 8'h55) mark_ok <= 1'b0;
      if (idx == 9'd511 && byte_d != 8'hAA) mark_ok <= 1'b0;
    end
  end

  // R3: once a bad marker byte is seen it stays recorded until the next load
  p_mark_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mark_ok && !clr) |=> !mark_ok);
  // R2: a bad tag byte stays recorded until the next load
  p_tag_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tag_ok && !clr) |=> !tag_ok);
endmodule

// File: rtl/sdl_word_pack.sv
module sdl_word_pack #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          in_v,
  input  logic [7:0]    in_d,
  output logic          in_ready,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data
);
  logic [1:0]  lane;
  logic [23:0] acc;
  logic        full;

  assign in_ready = !full;
  assign wr_valid = full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane <= '0; acc <= '0; full <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else if (clr) begin
      lane <= '0; acc <= '0; full <= 1'b0; wr_addr <= '0;
    end else begin
      if (full && wr_ready) begin
        full    <= 1'b0;
        wr_addr <= wr_addr + 1'b1;
      end
      if (in_v && !full) begin
        if (lane == 2'd3) begin
          wr_data <= {in_d, acc};
          full    <= 1'b1;
        end else begin
          acc[8*lane +: 8] <= in_d;
        end
        lane <= lane + 2'd1;
      end
    end
  end

  // R10: a pending word keeps address and data until accepted
  p_wr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !clr) |=> (wr_valid && $stable(wr_data) && $stable(wr_addr)));
  // R5: each accepted word advances the address by one
  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !clr) |=> (wr_addr == $past(wr_addr) + 1'b1));
endmodule

// File: rtl/sd_boot_loader.sv
module sd_boot_loader #(
  parameter int          REC_OFS   = 480,
  parameter int          IMG_WORDS = 1024,
  parameter int          TMO_CYC   = 100000,
  parameter logic [87:0] SIG_TEXT  = "BOOTIMAGE01",
  localparam int         AW        = $clog2(IMG_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [31:0]   req_sector,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [7:0]    rd_data,
  input  logic          rd_err,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data,
  output logic          done,
  output logic          fail,
  output logic [1:0]    fail_code
);
  import sdl_pkg::*;

  localparam int IMG_BYTES = IMG_WORDS * 4;
  localparam int NSEC      = (IMG_BYTES + SECT_BYTES - 1) / SECT_BYTES;
  localparam int IB_W      = $clog2(IMG_BYTES + 1);
  localparam int SEC_W     = $clog2(NSEC + 1);
  localparam int TW        = $clog2(TMO_CYC + 1);
  localparam logic [IB_W-1:0]  IMG_BYTES_V = IB_W'(IMG_BYTES);
  localparam logic [SEC_W-1:0] NSEC_V      = SEC_W'(NSEC);
  localparam logic [TW-1:0]    TMO_LAST    = TW'(TMO_CYC - 1);

  ld_state_t        state;
  logic [8:0]       bcnt;
  logic [IB_W-1:0]  img_cnt;
  logic [SEC_W-1:0] sec_left;
  logic [31:0]      cur_sec;
  logic [TW-1:0]    tmo;
  logic [1:0]       fcode;

  logic go, byte_hs, in_img, wait_ev, tmo_hit, in_rd;
  logic tag_ok, mark_ok, pk_ready, pk_valid, pk_clr;
  logic [31:0] start_sec;

  assign go      = start && (state == S_IDLE || state == S_FAIL);
  assign in_img  = img_cnt < IMG_BYTES_V;
  assign in_rd   = (state == S_RD0) || (state == S_RDN);
  assign byte_hs = rd_valid && rd_ready;
  assign wait_ev = (req_valid && !req_ready) || (rd_ready && !rd_valid);
  assign tmo_hit = wait_ev && (tmo == TMO_LAST);
  assign pk_clr  = go || (state == S_FAIL);

  always_comb begin
    req_valid  = (state == S_REQ0) || (state == S_REQN);
    req_sector = (state == S_REQN) ? cur_sec : 32'd0;
    case (state)
      S_RD0:   rd_ready = 1'b1;
      S_RDN:   rd_ready = in_img ? pk_ready : 1'b1;
      default: rd_ready = 1'b0;
    endcase
  end

  sdl_rec_check #(.REC_OFS(REC_OFS), .SIG_TEXT(SIG_TEXT)) u_rec (
    .clk(clk), .rst_n(rst_n), .clr(go),
    .byte_v(byte_hs && state == S_RD0), .idx(bcnt), .byte_d(rd_data),
    .tag_ok(tag_ok), .mark_ok(mark_ok), .start_sec(start_sec)
  );

  sdl_word_pack #(.AW(AW)) u_pack (
    .clk(clk), .rst_n(rst_n), .clr(pk_clr),
    .in_v(byte_hs && state == S_RDN && in_img), .in_d(rd_data), .in_ready(pk_ready),
    .wr_valid(pk_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  assign wr_valid  = pk_valid && (state != S_FAIL);
  assign done      = (state == S_DONE);
  assign fail      = (state == S_FAIL);
  assign fail_code = fcode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; bcnt <= '0; img_cnt <= '0; sec_left <= '0;
      cur_sec <= '0; tmo <= '0; fcode <= FC_NONE;
    end else begin
      tmo <= wait_ev ? tmo + 1'b1 : '0;
      if (go) begin
        state <= S_REQ0;
        fcode <= FC_NONE;
        tmo   <= '0;
      end else begin
        case (state)
          S_REQ0, S_REQN: begin
            bcnt <= '0;
            if (tmo_hit) begin
              state <= S_FAIL; fcode <= FC_IO;
            end else if (req_ready) begin
              state <= (state == S_REQ0) ? S_RD0 : S_RDN;
            end
          end
          S_RD0, S_RDN: begin
            if (rd_err || tmo_hit) begin
              state <= S_FAIL; fcode <= FC_IO;
            end else if (byte_hs) begin
              bcnt <= bcnt + 1'b1;
              if (state == S_RDN && in_img) img_cnt <= img_cnt + 1'b1;
              if (bcnt == 9'd511) begin
                if (state == S_RD0) begin
                  state <= S_EVAL;
                end else begin
                  cur_sec  <= cur_sec + 1'b1;
                  sec_left <= sec_left - 1'b1;
                  state    <= (sec_left == 1) ? S_DRAIN : S_REQN;
                end
              end
            end
          end
          S_EVAL: begin
            if (!mark_ok) begin
              state <= S_FAIL; fcode <= FC_MARK;
            end else if (!tag_ok) begin
              state <= S_FAIL; fcode <= FC_TAG;
            end else begin
              cur_sec  <= start_sec;
              sec_left <= NSEC_V;
              img_cnt  <= '0;
              state    <= S_REQN;
            end
          end
          S_DRAIN: if (!pk_valid) state <= S_DONE;
          S_DONE:  state <= S_IDLE;
          default: ;
        endcase
      end
    end
  end

  // R9: done is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9: failure status holds until a new start
  p_fail_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> (fail && $stable(fail_code)));
  // R2 / R3: a failed load neither writes nor requests
  p_fail_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (!wr_valid && !req_valid));
  // R7: any failure carries a nonzero reason
  p_code_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (fail_code != FC_NONE));
  // R10: a pending request holds its sector unless the load aborts
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !start) |=> ((req_valid && $stable(req_sector)) || fail));
  // R1: no traffic outside a load
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> (!req_valid && !rd_ready && !in_rd));
endmodule

// File: tb/sd_boot_loader_bench.sv
module sd_boot_loader_bench;
  localparam int IMG_WORDS = 200;
  localparam int TMO_CYC   = 64;
  localparam int REC_OFS   = 480;
  localparam int AW        = $clog2(IMG_WORDS);
  localparam logic [87:0] TAG = "BOOTIMAGE01";

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic req_valid, req_ready = 1'b0;
  logic [31:0] req_sector;
  logic rd_valid = 1'b0, rd_ready, rd_err = 1'b0;
  logic [7:0] rd_data = 8'h00;
  logic wr_valid, wr_ready = 1'b0;
  logic [AW-1:0] wr_addr;
  logic [31:0] wr_data;
  logic done, fail;
  logic [1:0] fail_code;

  always #10 clk = ~clk;

  sd_boot_loader #(.REC_OFS(REC_OFS), .IMG_WORDS(IMG_WORDS), .TMO_CYC(TMO_CYC)) u_sd_boot_loader (
    .clk(clk), .rst_n(rst_n), .start(start),
    .req_valid(req_valid), .req_ready(req_ready), .req_sector(req_sector),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_err(rd_err),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .fail(fail), .fail_code(fail_code)
  );

  // scenario controls, written by the main process at posedge+1
  logic [31:0] t_sec = 32'd37;
  bit t_bad_mark, t_bad_tag, t_bad_term, t_stall, card_clr;
  int t_err_req = -1, t_hang_req = -1;

  int nchk = 0, nfail = 0, mchk = 0, mfail = 0, nwr = 0;
  logic [AW-1:0] exp_a[$];
  logic [31:0]   exp_d[$];

  function automatic logic [7:0] img_byte(input logic [31:0] s, input int i);
    return 8'(s * 29 + 32'(i) * 7 + 32'(i >> 5));
  endfunction

  function automatic logic [7:0] sec0_byte(input int i);
    int p;
    p = i - REC_OFS;
    if (i == 510) return t_bad_mark ? 8'h54 : 8'h55;
    if (i == 511) return 8'hAA;
    if (p >= 0 && p < 11) return (t_bad_tag && p == 3) ? 8'h21 : TAG[8*(10-p) +: 8];
    if (p == 11) return t_bad_term ? 8'h01 : 8'h00;
    if (p >= 12 && p < 16) return t_sec[8*(p-12) +: 8];
    return 8'(i * 3);
  endfunction

  // card model
  int cst = 0, nreq = 0, bidx = 0;
  logic [31:0] csec = '0;
  logic [31:0] reqlog[8];
  logic [15:0] lf1 = 16'hACE1, lf2 = 16'h1D2B;
  always @(negedge clk) begin
    lf1 = {lf1[14:0], lf1[15] ^ lf1[13] ^ lf1[12] ^ lf1[10]};
    if (card_clr) begin
      cst = 0; nreq = 0; bidx = 0; req_ready = 1'b0; rd_valid = 1'b0; rd_err = 1'b0;
    end else begin
      rd_err = 1'b0;
      if (cst == 0) begin
        rd_valid  = 1'b0;
        req_ready = 1'b1;
        if (req_valid) begin
          if (nreq < 8) reqlog[nreq] = req_sector;
          nreq = nreq + 1; csec = req_sector; bidx = 0; cst = 1;
        end
      end else begin
        req_ready = 1'b0;
        if (nreq - 1 == t_err_req && bidx == 100) begin
          rd_valid = 1'b0; rd_err = 1'b1;
        end else if (nreq - 1 == t_hang_req) begin
          rd_valid = 1'b0;
        end else begin
          rd_valid = t_stall ? lf1[0] | lf1[3] : 1'b1;
          rd_data  = (csec == 0) ? sec0_byte(bidx) : img_byte(csec, bidx);
          if (rd_valid && rd_ready) begin
            bidx = bidx + 1;
            if (bidx == 512) cst = 0;
          end
        end
      end
    end
  end

  // RAM-side monitor / scoreboard
  logic pend = 1'b0;
  logic [31:0] pend_d = '0;
  logic [AW-1:0] pend_a = '0;
  always @(negedge clk) begin
    lf2 = {lf2[14:0], lf2[15] ^ lf2[13] ^ lf2[12] ^ lf2[10]};
    if (pend) begin
      mchk = mchk + 1;
      if (!(wr_valid && wr_data == pend_d && wr_addr == pend_a) && !fail) begin
        mfail = mfail + 1;
        $display("FAIL R10 held word changed: got %h@%0d expected %h@%0d", wr_data, wr_addr, pend_d, pend_a);
      end
    end
    wr_ready = t_stall ? lf2[1] | lf2[4] : 1'b1;
    pend = wr_valid && !wr_ready; pend_d = wr_data; pend_a = wr_addr;
    if (wr_valid && wr_ready) begin
      nwr = nwr + 1; mchk = mchk + 1;
      if (exp_d.size() == 0) begin
        mfail = mfail + 1;
        $display("FAIL R2 unexpected write: got %h@%0d expected none", wr_data, wr_addr);
      end else begin
        if (wr_data !== exp_d[0] || wr_addr !== exp_a[0]) begin
          mfail = mfail + 1;
          $display("FAIL R5 word: got %h@%0d expected %h@%0d", wr_data, wr_addr, exp_d[0], exp_a[0]);
        end
        void'(exp_d.pop_front()); void'(exp_a.pop_front());
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    nchk = nchk + 1;
    if (!ok) begin
      nfail = nfail + 1;
      $display("FAIL %s: got %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic push_image(input logic [31:0] s);
    for (int k = 0; k < IMG_WORDS; k++) begin
      logic [31:0] w;
      for (int j = 0; j < 4; j++) w[8*j +: 8] = img_byte(s + 32'((4*k+j) / 512), (4*k+j) % 512);
      exp_a.push_back(AW'(k)); exp_d.push_back(w);
    end
  endtask

  int dcount, ecode, w0, cyc;
  bit seen_done, seen_fail, hung;

  task automatic run(input bit image_phase);
    if (image_phase) push_image(t_sec);
    @(posedge clk); #1 card_clr = 1'b1;
    @(posedge clk); #1 card_clr = 1'b0; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    w0 = nwr; dcount = 0; seen_done = 0; seen_fail = 0; hung = 0; cyc = 0;
    while (!seen_done && !seen_fail && !hung) begin
      @(negedge clk);
      cyc++;
      if (done) begin dcount++; seen_done = 1; end
      if (fail) begin seen_fail = 1; ecode = int'(fail_code); end
      if (cyc > 20000) hung = 1;
    end
    chk(!hung, "watchdog expired", cyc, 20000);
  endtask

  task automatic flush();
    exp_a.delete(); exp_d.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!done && !fail && !req_valid && !wr_valid && !rd_ready, "R1 reset outputs quiet", {done, fail, req_valid, wr_valid}, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // good load with stalls on both sides
    t_sec = 32'd37; t_stall = 1;
    run(1);
    chk(seen_done, "R6 load completes", seen_done, 1);
    chk(nwr - w0 == IMG_WORDS, "R6 word count", nwr - w0, IMG_WORDS);
    chk(nreq == 3, "R4 request count", nreq, 3);
    chk(reqlog[0] == 0, "R1 first request sector", reqlog[0], 0);
    chk(reqlog[1] == 37 && reqlog[2] == 38, "R4 image sectors", reqlog[2], 38);
    chk(cst == 0, "R6 final sector fully consumed", cst, 0);
    repeat (4) begin @(negedge clk); if (done) dcount++; end
    chk(dcount == 1, "R9 done single pulse", dcount, 1);
    chk(exp_d.size() == 0, "R5 scoreboard drained", exp_d.size(), 0);
    flush();

    // multi-byte start sector, no stalls
    t_sec = 32'h0102_0304; t_stall = 0;
    run(1);
    chk(seen_done && reqlog[1] == 32'h0102_0304, "R4 little-endian start sector", reqlog[1], 32'h0102_0304);
    chk(nwr - w0 == IMG_WORDS, "R6 word count no stall", nwr - w0, IMG_WORDS);
    flush();

    // bad marker
    t_sec = 32'd9; t_bad_mark = 1;
    run(0);
    chk(seen_fail && ecode == 1, "R3 marker fail code", ecode, 1);
    chk(nwr == w0 && nreq == 1, "R3 nothing written or requested", nwr - w0, 0);
    repeat (10) @(negedge clk);
    chk(fail && fail_code == 2'd1, "R9 fail held", fail_code, 1);
    // marker and tag both bad
    t_bad_tag = 1;
    run(0);
    chk(seen_fail && ecode == 1, "R3 marker wins over tag", ecode, 1);
    // bad tag only
    t_bad_mark = 0;
    run(0);
    chk(seen_fail && ecode == 2, "R2 tag fail code", ecode, 2);
    chk(nwr == w0 && nreq == 1, "R2 nothing written", nwr - w0, 0);
    // bad terminator
    t_bad_tag = 0; t_bad_term = 1;
    run(0);
    chk(seen_fail && ecode == 2, "R2 terminator fail code", ecode, 2);
    t_bad_term = 0;

    // read error in second image sector
    t_sec = 32'd100; t_stall = 1; t_err_req = 2;
    run(1);
    chk(seen_fail && ecode == 3, "R7 read error code", ecode, 3);
    chk(nwr - w0 >= 128, "R7 words before error", nwr - w0, 128);
    flush(); t_err_req = -1;

    // hang in first image sector
    t_hang_req = 1;
    run(1);
    chk(seen_fail && ecode == 3, "R8 timeout code", ecode, 3);
    chk(cyc > TMO_CYC, "R8 timeout not early", cyc, TMO_CYC);
    flush(); t_hang_req = -1;

    // recovery after fail
    t_sec = 32'd5;
    run(1);
    chk(seen_done && !fail, "R9 fail clears on start", fail, 0);
    chk(nwr - w0 == IMG_WORDS, "R6 recovery word count", nwr - w0, IMG_WORDS);
    flush();

    nchk = nchk + mchk; nfail = nfail + mfail;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule